// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which power mode a small microcontroller is in. It can hold the chip in run, light sleep, soft standby, hard standby or reset, and it moves between them when the CPU executes its sleep instruction, when an interrupt arrives, or when one of two active-low board pins is pulled. Light sleep stops only the CPU, and the peripherals keep their clock. Soft standby stops the system clock and holds the peripherals in reset. The CPU registers, the RAM and the port latches are not touched in either mode. Hard standby is forced from the board and can be left only through reset.

Whether an interrupt may end a sleep depends on its source. A peripheral request counts only while its own enable bit is set. The CPU mask flag is captured at the moment the sleep is accepted, and while that captured flag is set only NMI can wake the chip. When the block leaves a low-power mode because of an interrupt, it raises a one-cycle strobe that starts the CPU's interrupt sequence. Both board pins pass through a two-flop synchronizer. The reset pin has the highest priority, the hard-standby pin comes next, and interrupts come last. No data moves through the block, so it has no valid/ready stream. Every pin is a plain level or strobe, and every output is registered.

Top module: `lpm_ctrl`

## Requirements
- R1: While `por_n` is low the mode is 3'b100 (reset): `cpu_halt`=1, `clk_en`=1, `periph_rst`=1, `wake_pulse`=0.
- R2: In run (3'b000), a `sleep_req` with `deep_sel`=0 gives light sleep (3'b001) on the next cycle, with `cpu_halt`=1, `clk_en`=1 and `periph_rst`=0.
- R3: In run, a `sleep_req` with `deep_sel`=1 gives soft standby (3'b010) on the next cycle, with `cpu_halt`=1, `clk_en`=0 and `periph_rst`=1.
- R4: In light sleep, NMI, or with the captured mask clear an external request or an enabled peripheral request, returns the block to run on the next cycle with `wake_pulse`=1.
- R5: In light sleep, a peripheral request whose bit in `per_ien` is 0 has no effect.
- R6: `irq_masked` is captured when the sleep is accepted. If the captured value is 1, only NMI ends light sleep, and later changes of `irq_masked` do not matter.
- R7: A synchronized low on `sysrst_pin_n` gives reset (3'b100) from any mode, even while `pwrdn_pin_n` is low too.
- R8: A synchronized low on `pwrdn_pin_n` while `sysrst_pin_n` is high gives hard standby (3'b011), with `cpu_halt`=1, `clk_en`=0 and `periph_rst`=1. Interrupts do not affect hard standby.
- R9: Hard standby moves to reset once the synchronized `pwrdn_pin_n` is high.
- R10: Reset moves to run once the synchronized `sysrst_pin_n` is high. In run, `cpu_halt`=0, `clk_en`=1 and `periph_rst`=0.
- R11: In soft standby, only NMI, or an external request with the captured mask clear, returns the block to run with `wake_pulse`=1. Peripheral requests are ignored.
- R12: `wake_pulse` is high for exactly one cycle, and only in the first run cycle after light sleep or soft standby.
- R13: Suppose a pin level is first sampled at clock edge k. The mode reacts to it at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sleep_req | input | 1 | One-cycle strobe from the CPU's sleep instruction |
| deep_sel | input | 1 | 0: sleep enters light sleep, 1: sleep enters soft standby |
| irq_masked | input | 1 | CPU interrupt-mask flag |
| nmi_req | input | 1 | Non-maskable interrupt request |
| ext_irq | input | 1 | External interrupt request |
| per_irq | input | NUM_IRQ | Peripheral interrupt requests |
| per_ien | input | NUM_IRQ | Per-source interrupt enable bits |
| sysrst_pin_n | input | 1 | Board reset pin, active low, asynchronous |
| pwrdn_pin_n | input | 1 | Board hard-standby pin, active low, asynchronous |
| cpu_halt | output | 1 | Stops CPU execution |
| clk_en | output | 1 | System clock enable |
| periph_rst | output | 1 | Holds the peripherals in reset |
| wake_pulse | output | 1 | One-cycle start of interrupt handling |
| mode | output | 3 | 000 run, 001 light sleep, 010 soft standby, 011 hard standby, 100 reset |

## Verification
Light sleep is entered several times, each time with a different wake source: an enabled peripheral, an external request, NMI with the mask captured high, and a peripheral request whose enable is off. Together these separate gating by the per-source enable from gating by the mask, and they show whether the mask is taken at entry or read live. Soft standby is given a peripheral request and then an external one, which shows whether its narrower wake set is respected. The pin patterns drive one pin low, or both pins low together, during sleep and during run. They show whether reset beats hard standby, whether an interrupt can override a pin, and whether the reaction comes exactly two synchronizer cycles after the first sample.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    MODE_RUN   = 3'b000,
    MODE_LIGHT = 3'b001,
    MODE_SOFT  = 3'b010,
    MODE_HARD  = 3'b011,
    MODE_RESET = 3'b100
  } lpm_mode_e;

  typedef struct packed {
    logic halt;
    logic clk_en;
    logic prst;
  } lpm_ctl_t;

  // Control outputs that belong to each mode.
  function automatic lpm_ctl_t lpm_decode(lpm_mode_e m);
    lpm_ctl_t c;
    unique case (m)
      MODE_RUN:   c = '{halt: 1'b0, clk_en: 1'b1, prst: 1'b0};
      MODE_LIGHT: c = '{halt: 1'b1, clk_en: 1'b1, prst: 1'b0};
      MODE_SOFT:  c = '{halt: 1'b1, clk_en: 1'b0, prst: 1'b1};
      MODE_HARD:  c = '{halt: 1'b1, clk_en: 1'b0, prst: 1'b1};
      default:    c = '{halt: 1'b1, clk_en: 1'b1, prst: 1'b1};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lpm_pin_sync.sv
module lpm_pin_sync #(
  parameter int               WIDTH  = 2,
  parameter int               STAGES = 2,
  parameter logic [WIDTH-1:0] INIT   = '1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) stg[0] <= INIT;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) stg[i] <= INIT;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  lpm_mode_e          mode,
  input  logic               mask_q,
  input  logic               nmi_req,
  input  logic               ext_irq,
  input  logic [NUM_IRQ-1:0] per_irq,
  input  logic [NUM_IRQ-1:0] per_ien,
  output logic               wake_ok
);

  logic [NUM_IRQ-1:0] hit;
  logic               per_any;

  // A source with its enable bit off cannot raise a request at all.
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    assign hit[i] = per_irq[i] & per_ien[i];
  end

  assign per_any = |hit;

  always_comb begin
    unique case (mode)
      MODE_LIGHT: wake_ok = nmi_req | (~mask_q & (ext_irq | per_any));
      MODE_SOFT:  wake_ok = nmi_req | (~mask_q & ext_irq);
      default:    wake_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      por_n,
  input  logic      sleep_req,
  input  logic      deep_sel,
  input  logic      irq_masked,
  input  logic      rst_ok,
  input  logic      pwr_ok,
  input  logic      wake_ok,
  output lpm_mode_e mode,
  output logic      mask_q,
  output logic      wake_pulse,
  output lpm_ctl_t  ctl
);

  lpm_mode_e nxt;
  logic      accept;
  logic      leave;

  always_comb begin
    nxt    = mode;
    accept = 1'b0;
    leave  = 1'b0;
    if (!rst_ok) begin
      nxt = MODE_RESET;
    end else if (!pwr_ok) begin
      nxt = MODE_HARD;
    end else begin
      unique case (mode)
        MODE_RUN: begin
          if (sleep_req) begin
            accept = 1'b1;
            nxt    = deep_sel ? MODE_SOFT : MODE_LIGHT;
          end
        end
        MODE_LIGHT, MODE_SOFT: begin
          if (wake_ok) begin
            leave = 1'b1;
            nxt   = MODE_RUN;
          end
        end
        MODE_HARD:  nxt = MODE_RESET;
        MODE_RESET: nxt = MODE_RUN;
        default:    nxt = MODE_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode       <= MODE_RESET;
      ctl        <= lpm_decode(MODE_RESET);
      wake_pulse <= 1'b0;
      mask_q     <= 1'b0;
    end else begin
      mode       <= nxt;
      ctl        <= lpm_decode(nxt);
      wake_pulse <= leave;
      if (accept) mask_q <= irq_masked;
    end
  end

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               sleep_req,
  input  logic               deep_sel,
  input  logic               irq_masked,
  input  logic               nmi_req,
  input  logic               ext_irq,
  input  logic [NUM_IRQ-1:0] per_irq,
  input  logic [NUM_IRQ-1:0] per_ien,
  input  logic               sysrst_pin_n,
  input  logic               pwrdn_pin_n,
  output logic               cpu_halt,
  output logic               clk_en,
  output logic               periph_rst,
  output logic               wake_pulse,
  output logic [2:0]         mode
);

  localparam int NUM_PINS = 2;

  logic [NUM_PINS-1:0] pins_s;
  logic                rst_ok;
  logic                pwr_ok;
  logic                mask_q;
  logic                wake_ok;
  lpm_mode_e           mode_e;
  lpm_ctl_t            ctl;

  lpm_pin_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES),
    .INIT  ({NUM_PINS{1'b1}})
  ) u_sync (
    .clk  (clk),
    .por_n(por_n),
    .d    ({pwrdn_pin_n, sysrst_pin_n}),
    .q    (pins_s)
  );

  assign rst_ok = pins_s[0];
  assign pwr_ok = pins_s[1];

  lpm_wake_qual #(.NUM_IRQ(NUM_IRQ)) u_qual (
    .mode   (mode_e),
    .mask_q (mask_q),
    .nmi_req(nmi_req),
    .ext_irq(ext_irq),
    .per_irq(per_irq),
    .per_ien(per_ien),
    .wake_ok(wake_ok)
  );

  lpm_mode_fsm u_fsm (
    .clk       (clk),
    .por_n     (por_n),
    .sleep_req (sleep_req),
    .deep_sel  (deep_sel),
    .irq_masked(irq_masked),
    .rst_ok    (rst_ok),
    .pwr_ok    (pwr_ok),
    .wake_ok   (wake_ok),
    .mode      (mode_e),
    .mask_q    (mask_q),
    .wake_pulse(wake_pulse),
    .ctl       (ctl)
  );

  assign mode       = mode_e;
  assign cpu_halt   = ctl.halt;
  assign clk_en     = ctl.clk_en;
  assign periph_rst = ctl.prst;

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
  import lpm_pkg::*;
(
  input logic       clk,
  input logic       por_n,
  input logic       sleep_req,
  input logic       deep_sel,
  input logic       nmi_req,
  input logic [2:0] mode,
  input logic       cpu_halt,
  input logic       clk_en,
  input logic       periph_rst,
  input logic       wake_pulse,
  input logic       rst_ok,
  input logic       pwr_ok,
  input logic       mask_q
);

  p_light_entry_r2: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_RUN && sleep_req && !deep_sel && rst_ok && pwr_ok) |=> (mode == MODE_LIGHT));

  p_soft_entry_r3: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_RUN && sleep_req && deep_sel && rst_ok && pwr_ok) |=> (mode == MODE_SOFT));

  p_soft_ctl_r3: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_SOFT) |-> (cpu_halt && !clk_en && periph_rst));

  p_nmi_wake_r4: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_LIGHT && nmi_req && rst_ok && pwr_ok) |=> (mode == MODE_RUN && wake_pulse));

  p_masked_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_LIGHT && mask_q && !nmi_req && rst_ok && pwr_ok) |=> (mode == MODE_LIGHT));

  p_reset_first_r7: assert property (@(posedge clk) disable iff (!por_n)
    !rst_ok |=> (mode == MODE_RESET));

  p_hard_entry_r8: assert property (@(posedge clk) disable iff (!por_n)
    (rst_ok && !pwr_ok) |=> (mode == MODE_HARD));

  p_hard_exit_r9: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_HARD && rst_ok && pwr_ok) |=> (mode == MODE_RESET));

  p_run_ctl_r10: assert property (@(posedge clk) disable iff (!por_n)
    (mode == MODE_RUN) |-> (!cpu_halt && clk_en && !periph_rst));

  p_wake_single_r12: assert property (@(posedge clk) disable iff (!por_n)
    wake_pulse |=> !wake_pulse);

  p_wake_origin_r12: assert property (@(posedge clk) disable iff (!por_n)
    wake_pulse |-> (mode == MODE_RUN &&
                    ($past(mode) == MODE_LIGHT || $past(mode) == MODE_SOFT)));

endmodule

bind lpm_ctrl lpm_ctrl_chk u_lpm_chk (
  .clk       (clk),
  .por_n     (por_n),
  .sleep_req (sleep_req),
  .deep_sel  (deep_sel),
  .nmi_req   (nmi_req),
  .mode      (mode),
  .cpu_halt  (cpu_halt),
  .clk_en    (clk_en),
  .periph_rst(periph_rst),
  .wake_pulse(wake_pulse),
  .rst_ok    (rst_ok),
  .pwr_ok    (pwr_ok),
  .mask_q    (mask_q)
);

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NIRQ       = 4;
  localparam int WD_CYCLES  = 20000;

  // mode codes taken from the requirements
  localparam logic [2:0] RUN = 3'b000, LIGHT = 3'b001, SOFT = 3'b010,
                         HARD = 3'b011, RST = 3'b100;

  logic            clk = 1'b0;
  logic            por_n = 1'b0;
  logic            sleep_req = 1'b0, deep_sel = 1'b0, irq_masked = 1'b0;
  logic            nmi_req = 1'b0, ext_irq = 1'b0;
  logic [NIRQ-1:0] per_irq = '0, per_ien = '0;
  logic            sysrst_pin_n = 1'b1, pwrdn_pin_n = 1'b1;
  logic            cpu_halt, clk_en, periph_rst, wake_pulse;
  logic [2:0]      mode;

  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_ctrl #(.NUM_IRQ(NIRQ)) u_lpm_ctrl (
    .clk(clk), .por_n(por_n), .sleep_req(sleep_req), .deep_sel(deep_sel),
    .irq_masked(irq_masked), .nmi_req(nmi_req), .ext_irq(ext_irq),
    .per_irq(per_irq), .per_ien(per_ien), .sysrst_pin_n(sysrst_pin_n),
    .pwrdn_pin_n(pwrdn_pin_n), .cpu_halt(cpu_halt), .clk_en(clk_en),
    .periph_rst(periph_rst), .wake_pulse(wake_pulse), .mode(mode)
  );

  // Behavioural reference: pin delay lines, captured mask, current mode.
  logic [2:0] m_mode = RST;
  logic       m_wake = 1'b0, m_mask = 1'b0;
  logic [1:0] m_rst_line = 2'b11, m_pwr_line = 2'b11;

  always @(posedge clk) begin
    if (!por_n) begin
      m_mode = RST; m_wake = 1'b0; m_mask = 1'b0;
      m_rst_line = 2'b11; m_pwr_line = 2'b11;
    end else begin
      m_wake = 1'b0;
      if (!m_rst_line[1])      m_mode = RST;
      else if (!m_pwr_line[1]) m_mode = HARD;
      else if (m_mode == RUN) begin
        if (sleep_req) begin
          m_mask = irq_masked;
          m_mode = deep_sel ? SOFT : LIGHT;
        end
      end else if (m_mode == LIGHT) begin
        if (nmi_req || (!m_mask && (ext_irq || (per_irq & per_ien) != 0))) begin
          m_mode = RUN; m_wake = 1'b1;
        end
      end else if (m_mode == SOFT) begin
        if (nmi_req || (!m_mask && ext_irq)) begin
          m_mode = RUN; m_wake = 1'b1;
        end
      end else if (m_mode == HARD) m_mode = RST;
      else m_mode = RUN;
      m_rst_line = {m_rst_line[0], sysrst_pin_n};
      m_pwr_line = {m_pwr_line[0], pwrdn_pin_n};
    end
  end

  task automatic report(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Compare every output with the reference model.
  task automatic model_cmp();
    logic eh, ec, ep;
    eh = (m_mode != RUN);
    ec = (m_mode == RUN || m_mode == LIGHT || m_mode == RST);
    ep = (m_mode == SOFT || m_mode == HARD || m_mode == RST);
    report(cur_req, "model", int'({mode, cpu_halt, clk_en, periph_rst, wake_pulse}),
           int'({m_mode, eh, ec, ep, m_wake}));
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      model_cmp();
    end
  endtask

  task automatic expect_mw(string req, logic [2:0] em, logic ew);
    report(req, "mode", int'(mode), int'(em));
    report(req, "wake_pulse", int'(wake_pulse), int'(ew));
  endtask

  task automatic expect_ctl(string req, logic eh, logic ec, logic ep);
    report(req, "halt/clk_en/periph_rst", int'({cpu_halt, clk_en, periph_rst}),
           int'({eh, ec, ep}));
  endtask

  task automatic enter_sleep(logic deep, logic masked);
    deep_sel = deep; irq_masked = masked; sleep_req = 1'b1;
    tick();
    sleep_req = 1'b0;
  endtask

  initial begin
    // R1: held in power-on reset
    cur_req = "R1";
    tick(3);
    expect_mw("R1", RST, 1'b0);
    expect_ctl("R1", 1'b1, 1'b1, 1'b1);
    por_n = 1'b1;
    cur_req = "R10";
    tick();
    expect_mw("R10", RUN, 1'b0);
    expect_ctl("R10", 1'b0, 1'b1, 1'b0);

    // R2 light sleep, R5 disabled source, R4 enabled source, R12 pulse width
    cur_req = "R2";
    enter_sleep(1'b0, 1'b0);
    expect_mw("R2", LIGHT, 1'b0);
    expect_ctl("R2", 1'b1, 1'b1, 1'b0);
    cur_req = "R5";
    per_irq = 4'b0010; per_ien = 4'b1101;
    tick(3);
    expect_mw("R5", LIGHT, 1'b0);
    cur_req = "R4";
    per_ien = 4'b0010;
    tick();
    expect_mw("R4", RUN, 1'b1);
    per_irq = '0; per_ien = '0;
    cur_req = "R12";
    tick();
    expect_mw("R12", RUN, 1'b0);

    // R6: mask captured at entry, later clear does not matter
    cur_req = "R6";
    enter_sleep(1'b0, 1'b1);
    irq_masked = 1'b0; ext_irq = 1'b1; per_irq = 4'b1000; per_ien = 4'b1000;
    tick(3);
    expect_mw("R6", LIGHT, 1'b0);
    nmi_req = 1'b1;
    tick();
    expect_mw("R6", RUN, 1'b1);
    nmi_req = 1'b0; ext_irq = 1'b0; per_irq = '0; per_ien = '0;
    tick();
    expect_mw("R12", RUN, 1'b0);

    // R4: external request wakes when unmasked
    cur_req = "R4";
    enter_sleep(1'b0, 1'b0);
    ext_irq = 1'b1;
    tick();
    expect_mw("R4", RUN, 1'b1);
    ext_irq = 1'b0;
    tick();

    // R3 soft standby, R11 its wake set
    cur_req = "R3";
    enter_sleep(1'b1, 1'b0);
    expect_mw("R3", SOFT, 1'b0);
    expect_ctl("R3", 1'b1, 1'b0, 1'b1);
    cur_req = "R11";
    per_irq = 4'b0001; per_ien = 4'b0001;
    tick(2);
    expect_mw("R11", SOFT, 1'b0);
    ext_irq = 1'b1;
    tick();
    expect_mw("R11", RUN, 1'b1);
    ext_irq = 1'b0; per_irq = '0; per_ien = '0; deep_sel = 1'b0;
    tick();

    // R13 latency and R8 hard standby from light sleep
    cur_req = "R13";
    enter_sleep(1'b0, 1'b1);
    irq_masked = 1'b0;
    pwrdn_pin_n = 1'b0;
    tick(2);
    expect_mw("R13", LIGHT, 1'b0);
    tick();
    expect_mw("R13", HARD, 1'b0);
    cur_req = "R8";
    expect_ctl("R8", 1'b1, 1'b0, 1'b1);
    nmi_req = 1'b1; ext_irq = 1'b1;
    tick(2);
    expect_mw("R8", HARD, 1'b0);
    nmi_req = 1'b0; ext_irq = 1'b0;
    cur_req = "R9";
    pwrdn_pin_n = 1'b1;
    tick(2);
    expect_mw("R9", HARD, 1'b0);
    tick();
    expect_mw("R9", RST, 1'b0);
    cur_req = "R10";
    tick();
    expect_mw("R10", RUN, 1'b0);
    expect_ctl("R10", 1'b0, 1'b1, 1'b0);

    // R7: both pins low together, reset wins
    cur_req = "R7";
    sysrst_pin_n = 1'b0; pwrdn_pin_n = 1'b0;
    tick(3);
    expect_mw("R7", RST, 1'b0);
    expect_ctl("R7", 1'b1, 1'b1, 1'b1);
    tick(2);
    expect_mw("R7", RST, 1'b0);
    sysrst_pin_n = 1'b1; pwrdn_pin_n = 1'b1;
    tick(2);
    expect_mw("R7", RST, 1'b0);
    cur_req = "R10";
    tick();
    expect_mw("R10", RUN, 1'b0);

    // R7: reset pin during light sleep beats a coincident pin-side wait
    cur_req = "R7";
    enter_sleep(1'b0, 1'b1);
    irq_masked = 1'b0;
    sysrst_pin_n = 1'b0;
    tick(2);
    expect_mw("R13", LIGHT, 1'b0);
    tick();
    expect_mw("R7", RST, 1'b0);
    sysrst_pin_n = 1'b1;
    tick(3);
    expect_mw("R10", RUN, 1'b0);

    // R7: reset pin from soft standby
    enter_sleep(1'b1, 1'b0);
    deep_sel = 1'b0;
    sysrst_pin_n = 1'b0;
    tick(3);
    expect_mw("R7", RST, 1'b0);
    sysrst_pin_n = 1'b1;
    tick(4);
    expect_mw("R10", RUN, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule